// File: doc/BRIEF.md
# PHY Link Bring-Up Sequencer

This block configures an Ethernet PHY after a start pulse. It works only through a management-register command port. Each command is a single read or write of a 16-bit PHY register, and the block hands it to an external management controller that does the serial framing.

A run has up to four phases:
- **Discovery (optional).** The block scans every PHY address to find the device that answers.
- **Reset.** It software-resets that PHY.
- **Link setup.** It either advertises 10/100 capability and runs auto-negotiation, or it writes a fixed speed and duplex and reads the result back.
- **Resolution.** In auto-negotiation mode it resolves the link from the partner and gigabit status registers, and writes the outcome back into the control register.

At the end the block reports the speed, the duplex and the selected PHY address. It also raises `cfg_done` and, when the run failed, `cfg_error`. Both flags stay set until the next start. The mode inputs and the fixed PHY address are captured when the run starts. The block does nothing more once configuration finishes.

Register indices used: control 0, status 1, advertisement 4, link partner 5, gigabit status 10. Speed encoding on `link_speed`: 0 is 10 Mb/s, 1 is 100 Mb/s, 2 is 1000 Mb/s.

Top module: `phy_link_seq`

## Requirements
- R1: A `start` pulse while idle captures the mode inputs and begins a run. A `start` during a run is ignored, and the command stream and the result are unchanged.
- R2: A command is presented with `req_valid`, and its fields stay stable until the cycle `req_ready` is high. Only one command is outstanding at a time. The next command appears only after `rsp_valid` has answered the previous one, and this applies to writes as well as reads.
- R3: With discovery on, the addresses are tried from 0 upward. For each address the block reads control, writes it back with bit 12 inverted, and reads control again. If bit 12 differs from the first read, the block writes back the first-read value and selects that address (`phy_addr_sel`).
- R4: With discovery on, if no address from 0 to 31 keeps the inverted bit, the run ends with `cfg_error` after exactly 96 commands.
- R5: Reset writes 0x8000 to control and then reads control repeatedly until bit 15 reads 0.
- R6: If control bit 15 is still set when the reset poll window of `RST_LIMIT` cycles has elapsed, the run ends with `cfg_error`.
- R7: In auto-negotiation mode, after reset the block writes 0x01E1 to the advertisement register. It then writes 0x1200 (enable plus restart) to control, and polls status until bit 5 is set.
- R8: After completion the block reads the partner register, then gigabit status, and resolves the link in this priority order:
  - gigabit status bit 11 gives 1000 full;
  - gigabit status bit 10 gives 1000 half;
  - partner bit 8 gives 100 full;
  - partner bit 7 gives 100 half;
  - partner bit 6 gives 10 full;
  - otherwise the link is 10 half.
- R9: The final auto-negotiation write to control is 0x1200, with bit 6 added for 1000 Mb/s, bit 13 added for 100 Mb/s, and bit 8 added for full duplex.
- R10: If status bit 5 has not been seen within `AN_LIMIT` cycles of polling, the run ends with `cfg_error`.
- R11: In forced mode the block writes 0x2100 to control. `force_10` clears bit 13 and `force_half` clears bit 8. It then reads control and reports full duplex from bit 8, and speed from bit 6 first, then bit 13, otherwise 10 Mb/s.
- R12: `cfg_done` and `cfg_error` are low after reset. Both clear on an accepted start and are sticky afterwards. On a successful run, `link_speed` and `link_full` hold the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration run (pulse) |
| probe_en | input | 1 | Scan addresses to discover the PHY |
| autoneg_en | input | 1 | 1: auto-negotiate, 0: forced speed/duplex |
| force_10 | input | 1 | Forced mode: drop 100 Mb/s bit |
| force_half | input | 1 | Forced mode: drop full-duplex bit |
| phy_addr_cfg | input | ADDR_W | PHY address used when discovery is off |
| req_valid | output | 1 | Command request valid |
| req_ready | input | 1 | Controller accepts the command |
| req_write | output | 1 | 1 = write, 0 = read |
| req_phy | output | ADDR_W | PHY address of the command |
| req_reg | output | 5 | Register index of the command |
| req_wdata | output | 16 | Write data |
| rsp_valid | input | 1 | Command completed (pulse) |
| rsp_rdata | input | 16 | Read data, valid with rsp_valid |
| link_speed | output | 2 | Resolved speed (0/1/2 = 10/100/1000) |
| link_full | output | 1 | Resolved full duplex |
| cfg_done | output | 1 | Run finished (sticky) |
| cfg_error | output | 1 | Run failed (sticky) |
| phy_addr_sel | output | ADDR_W | PHY address in use |

## Verification
The hardest situations to reach are the two poll timeouts and the exhaustive discovery miss, because they depend on the PHY never answering as hoped.

The bench's behavioural PHY model can keep the reset bit set forever, never report auto-negotiation complete, or leave every address unresponsive (all-ones reads, writes ignored). The block is then driven into the timeout or the full 32-address scan.

Once the expected commands are used up, the model accepts only further polls of the same register. This makes the number of timeout polls free while any other stray command is still caught.

Response latency and periodic `req_ready` stalls vary between runs so that request holding is exercised.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  localparam int DATA_W = 16;
  localparam int RIDX_W = 5;

  // register indices
  localparam logic [RIDX_W-1:0] RI_CTRL  = 5'd0;
  localparam logic [RIDX_W-1:0] RI_STAT  = 5'd1;
  localparam logic [RIDX_W-1:0] RI_ADV   = 5'd4;
  localparam logic [RIDX_W-1:0] RI_PART  = 5'd5;
  localparam logic [RIDX_W-1:0] RI_GSTAT = 5'd10;

  // control register bits
  localparam int CB_RST     = 15;
  localparam int CB_SPD100  = 13;
  localparam int CB_ANEN    = 12;
  localparam int CB_RESTART = 9;
  localparam int CB_FULL    = 8;
  localparam int CB_SPD1G   = 6;
  // status, gigabit status and partner bits
  localparam int SB_ANDONE  = 5;
  localparam int GB_1G_FULL = 11;
  localparam int GB_1G_HALF = 10;
  localparam int PB_100F    = 8;
  localparam int PB_100H    = 7;
  localparam int PB_10F     = 6;

  localparam logic [DATA_W-1:0] ADV_10_100 = 16'h01E1;

  typedef enum logic [1:0] {
    SPD_10   = 2'd0,
    SPD_100  = 2'd1,
    SPD_1000 = 2'd2
  } speed_e;

  typedef enum logic [1:0] {
    PORT_IDLE,
    PORT_REQ,
    PORT_WAIT
  } port_state_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PR_RD0,
    ST_PR_FLIP,
    ST_PR_RD1,
    ST_PR_BACK,
    ST_RS_WR,
    ST_RS_POLL,
    ST_AN_ADV,
    ST_AN_CTL,
    ST_AN_POLL,
    ST_AN_PART,
    ST_AN_GIG,
    ST_AN_FIN,
    ST_FX_WR,
    ST_FX_RD
  } seq_state_e;

  function automatic logic [DATA_W-1:0] bitv(input int pos);
    logic [DATA_W-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] forced_ctrl(input logic drop100,
                                                    input logic drophalf);
    logic [DATA_W-1:0] v;
    v = bitv(CB_SPD100) | bitv(CB_FULL);
    if (drop100)  v[CB_SPD100] = 1'b0;
    if (drophalf) v[CB_FULL]   = 1'b0;
    return v;
  endfunction

  function automatic speed_e ctrl_speed(input logic [DATA_W-1:0] c);
    if (c[CB_SPD1G])       return SPD_1000;
    else if (c[CB_SPD100]) return SPD_100;
    else                   return SPD_10;
  endfunction

endpackage

// File: rtl/phy_cmd_port.sv
module phy_cmd_port
  import phy_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic req_valid,
  output logic idle,
  output logic cmd_done
);

  port_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PORT_IDLE: if (go)        st_d = PORT_REQ;
      PORT_REQ:  if (req_ready) st_d = PORT_WAIT;
      PORT_WAIT: if (rsp_valid) st_d = PORT_IDLE;
      default:                  st_d = PORT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PORT_IDLE;
    else        st_q <= st_d;
  end

  assign req_valid = (st_q == PORT_REQ);
  assign idle      = (st_q == PORT_IDLE);
  assign cmd_done  = (st_q == PORT_WAIT) && rsp_valid;

  // R2: a presented request is not withdrawn before acceptance
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid);

  // R2: no new request in the cycle a response closes the previous one
  p_single_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !req_valid);

endmodule

// File: rtl/phy_poll_timer.sv
module phy_poll_timer #(
  parameter int LIMIT = 1000,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q >= CW'(LIMIT));
  assign cnt_en  = clr || !expired;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R6 / R10: an expired window stays expired until cleared
  p_expiry_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !clr |=> expired);

endmodule

// File: rtl/phy_link_resolve.sv
module phy_link_resolve
  import phy_seq_pkg::*;
(
  input  logic [DATA_W-1:0] gstat,
  input  logic [DATA_W-1:0] part,
  output speed_e            speed,
  output logic              full
);

  always_comb begin
    if (gstat[GB_1G_FULL]) begin
      speed = SPD_1000; full = 1'b1;
    end else if (gstat[GB_1G_HALF]) begin
      speed = SPD_1000; full = 1'b0;
    end else if (part[PB_100F]) begin
      speed = SPD_100;  full = 1'b1;
    end else if (part[PB_100H]) begin
      speed = SPD_100;  full = 1'b0;
    end else if (part[PB_10F]) begin
      speed = SPD_10;   full = 1'b1;
    end else begin
      speed = SPD_10;   full = 1'b0;
    end
  end

endmodule

// File: rtl/phy_link_seq.sv
module phy_link_seq
  import phy_seq_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int RST_LIMIT = 50000,
  parameter int AN_LIMIT  = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              probe_en,
  input  logic              autoneg_en,
  input  logic              force_10,
  input  logic              force_half,
  input  logic [ADDR_W-1:0] phy_addr_cfg,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_phy,
  output logic [4:0]        req_reg,
  output logic [15:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic [15:0]       rsp_rdata,
  output logic [1:0]        link_speed,
  output logic              link_full,
  output logic              cfg_done,
  output logic              cfg_error,
  output logic [ADDR_W-1:0] phy_addr_sel
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam logic [DATA_W-1:0] AN_GO     = bitv(CB_ANEN) | bitv(CB_RESTART);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  // state
  seq_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] orig_q, orig_d;
  logic [DATA_W-1:0] part_q, part_d;
  speed_e            spd_q, spd_d;
  logic              full_q, full_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              m_probe_q, m_an_q, m_f10_q, m_fhalf_q;
  logic              accept_start;

  // command port
  logic port_idle, cmd_done, cmd_go;
  assign cmd_go = port_idle && (st_q != ST_IDLE);

  phy_cmd_port u_port (
    .clk       (clk),
    .rst_n     (srst_n),
    .go        (cmd_go),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .req_valid (req_valid),
    .idle      (port_idle),
    .cmd_done  (cmd_done)
  );

  // poll windows
  logic rst_expired, an_expired;

  phy_poll_timer #(.LIMIT(RST_LIMIT)) u_rst_win (
    .clk     (clk),
    .rst_n   (srst_n),
    .clr     (st_q != ST_RS_POLL),
    .expired (rst_expired)
  );

  phy_poll_timer #(.LIMIT(AN_LIMIT)) u_an_win (
    .clk     (clk),
    .rst_n   (srst_n),
    .clr     (st_q != ST_AN_POLL),
    .expired (an_expired)
  );

  // link resolution from the gigabit status response
  speed_e res_spd;
  logic   res_full;

  phy_link_resolve u_resolve (
    .gstat (rsp_rdata),
    .part  (part_q),
    .speed (res_spd),
    .full  (res_full)
  );

  // command contents per state
  logic [DATA_W-1:0] an_final;
  always_comb begin
    an_final = AN_GO;
    if (spd_q == SPD_1000) an_final[CB_SPD1G]  = 1'b1;
    if (spd_q == SPD_100)  an_final[CB_SPD100] = 1'b1;
    if (full_q)            an_final[CB_FULL]   = 1'b1;
  end

  always_comb begin
    req_write = 1'b0;
    req_reg   = RI_CTRL;
    req_wdata = '0;
    unique case (st_q)
      ST_PR_FLIP: begin req_write = 1'b1; req_wdata = orig_q ^ bitv(CB_ANEN); end
      ST_PR_BACK: begin req_write = 1'b1; req_wdata = orig_q; end
      ST_RS_WR:   begin req_write = 1'b1; req_wdata = bitv(CB_RST); end
      ST_AN_ADV:  begin req_write = 1'b1; req_reg = RI_ADV; req_wdata = ADV_10_100; end
      ST_AN_CTL:  begin req_write = 1'b1; req_wdata = AN_GO; end
      ST_AN_POLL: req_reg = RI_STAT;
      ST_AN_PART: req_reg = RI_PART;
      ST_AN_GIG:  req_reg = RI_GSTAT;
      ST_AN_FIN:  begin req_write = 1'b1; req_wdata = an_final; end
      ST_FX_WR:   begin req_write = 1'b1; req_wdata = forced_ctrl(m_f10_q, m_fhalf_q); end
      default:    ;
    endcase
  end
  assign req_phy = addr_q;

  // next state
  assign accept_start = (st_q == ST_IDLE) && start;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    orig_d = orig_q;
    part_d = part_q;
    spd_d  = spd_q;
    full_d = full_q;
    done_d = done_q;
    err_d  = err_q;
    if (accept_start) begin
      done_d = 1'b0;
      err_d  = 1'b0;
      if (probe_en) begin
        st_d   = ST_PR_RD0;
        addr_d = '0;
      end else begin
        st_d   = ST_RS_WR;
        addr_d = phy_addr_cfg;
      end
    end else if (cmd_done) begin
      unique case (st_q)
        ST_PR_RD0: begin
          orig_d = rsp_rdata;
          st_d   = ST_PR_FLIP;
        end
        ST_PR_FLIP: st_d = ST_PR_RD1;
        ST_PR_RD1: begin
          if (rsp_rdata[CB_ANEN] != orig_q[CB_ANEN]) begin
            st_d = ST_PR_BACK;
          end else if (addr_q == LAST_ADDR) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            err_d  = 1'b1;
          end else begin
            addr_d = addr_q + 1'b1;
            st_d   = ST_PR_RD0;
          end
        end
        ST_PR_BACK: st_d = ST_RS_WR;
        ST_RS_WR:   st_d = ST_RS_POLL;
        ST_RS_POLL: begin
          if (!rsp_rdata[CB_RST]) begin
            st_d = m_an_q ? ST_AN_ADV : ST_FX_WR;
          end else if (rst_expired) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            err_d  = 1'b1;
          end
        end
        ST_AN_ADV: st_d = ST_AN_CTL;
        ST_AN_CTL: st_d = ST_AN_POLL;
        ST_AN_POLL: begin
          if (rsp_rdata[SB_ANDONE]) begin
            st_d = ST_AN_PART;
          end else if (an_expired) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            err_d  = 1'b1;
          end
        end
        ST_AN_PART: begin
          part_d = rsp_rdata;
          st_d   = ST_AN_GIG;
        end
        ST_AN_GIG: begin
          spd_d  = res_spd;
          full_d = res_full;
          st_d   = ST_AN_FIN;
        end
        ST_AN_FIN: begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
        ST_FX_WR: st_d = ST_FX_RD;
        ST_FX_RD: begin
          spd_d  = ctrl_speed(rsp_rdata);
          full_d = rsp_rdata[CB_FULL];
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      orig_q <= '0;
      part_q <= '0;
      spd_q  <= SPD_10;
      full_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      orig_q <= orig_d;
      part_q <= part_d;
      spd_q  <= spd_d;
      full_q <= full_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      m_probe_q <= 1'b0;
      m_an_q    <= 1'b0;
      m_f10_q   <= 1'b0;
      m_fhalf_q <= 1'b0;
    end else if (accept_start) begin
      m_probe_q <= probe_en;
      m_an_q    <= autoneg_en;
      m_f10_q   <= force_10;
      m_fhalf_q <= force_half;
    end
  end

  assign link_speed   = spd_q;
  assign link_full    = full_q;
  assign cfg_done     = done_q;
  assign cfg_error    = err_q;
  assign phy_addr_sel = addr_q;

  // R2: request fields hold while waiting for acceptance
  p_req_stable_r2: assert property (@(posedge clk) disable iff (!srst_n)
    req_valid && !req_ready |=> $stable(req_write) && $stable(req_reg) &&
                                $stable(req_wdata) && $stable(req_phy));

  // R12: completion flags are sticky without a start
  p_done_sticky_r12: assert property (@(posedge clk) disable iff (!srst_n)
    cfg_done && !start |=> cfg_done);

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!srst_n)
    cfg_error && !start |=> cfg_error);

  // R12: an accepted start clears both flags
  p_start_clears_r12: assert property (@(posedge clk) disable iff (!srst_n)
    accept_start |=> !cfg_done && !cfg_error);

  // R5: in the reset phase the presented write carries the reset bit
  p_reset_write_r5: assert property (@(posedge clk) disable iff (!srst_n)
    req_valid && (st_q == ST_RS_WR) |-> req_write && req_wdata[CB_RST]);

  // R8: reported speed is one of the three legal encodings
  p_speed_legal_r8: assert property (@(posedge clk) disable iff (!srst_n)
    cfg_done && !cfg_error |-> link_speed != 2'b11);

  // R1: the mode captured at start does not change during a run
  p_mode_frozen_r1: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q != ST_IDLE) && (st_d != ST_IDLE) |=> $stable(m_an_q) && $stable(m_probe_q));

endmodule

// File: tb/test_phy_link_seq.sv
module test_phy_link_seq;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        probe_en, autoneg_en, force_10, force_half;
  logic [4:0]  phy_addr_cfg;
  logic        req_valid, req_ready, req_write;
  logic [4:0]  req_phy, req_reg;
  logic [15:0] req_wdata;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [1:0]  link_speed;
  logic        link_full, cfg_done, cfg_error;
  logic [4:0]  phy_addr_sel;

  phy_link_seq #(.ADDR_W(5), .RST_LIMIT(150), .AN_LIMIT(200)) i_phy_link_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .probe_en(probe_en),
    .autoneg_en(autoneg_en), .force_10(force_10), .force_half(force_half),
    .phy_addr_cfg(phy_addr_cfg), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .link_speed(link_speed), .link_full(link_full), .cfg_done(cfg_done),
    .cfg_error(cfg_error), .phy_addr_sel(phy_addr_sel)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit finished = 0;

  // expected command stream
  bit    q_wr[$];
  int    q_phy[$];
  int    q_reg[$];
  int    q_dat[$];
  string q_tag[$];
  int    tail_reg = -1;
  int    tail_phy = 0;
  bit    running = 0;

  // PHY model
  int          m_resp = -1;
  logic [15:0] m_ctrl, m_adv, m_part, m_gig;
  int          m_rst_left, m_an_left;
  bit          m_an_done, m_gig_stuck;

  // responder
  int          lat = 1;
  int          stall_mod = 0;
  bit          pend = 0;
  int          pcnt = 0;
  logic [15:0] pdata;
  bit          held = 0;
  logic [26:0] held_f;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic push(input bit wr, input int phy, input int rg, input int dat, input string tag);
    q_wr.push_back(wr); q_phy.push_back(phy); q_reg.push_back(rg);
    q_dat.push_back(dat); q_tag.push_back(tag);
  endtask

  function automatic logic [15:0] model_read(input int a, input int r);
    if (a != m_resp) return 16'hFFFF;
    case (r)
      0: begin
        if (m_ctrl[15]) begin
          if (m_rst_left == 0) m_ctrl[15] = 1'b0;
          else if (m_rst_left > 0) m_rst_left--;
        end
        return m_ctrl | (m_gig_stuck ? 16'h0040 : 16'h0000);
      end
      1: begin
        if (!m_an_done) begin
          if (m_an_left == 0) m_an_done = 1;
          else if (m_an_left > 0) m_an_left--;
        end
        return 16'h7809 | (m_an_done ? 16'h0020 : 16'h0000);
      end
      4: return m_adv;
      5: return m_part;
      10: return m_gig;
      default: return 16'h0000;
    endcase
  endfunction

  int cfg_rst_reads, cfg_an_reads;

  function automatic void model_write(input int a, input int r, input logic [15:0] d);
    if (a != m_resp) return;
    if (r == 0) begin
      if (d[15]) begin
        m_ctrl = 16'h9140;
        m_rst_left = cfg_rst_reads;
      end else begin
        m_ctrl = d;
        if (d[9]) begin
          m_an_done = 0;
          m_an_left = cfg_an_reads;
        end
      end
    end else if (r == 4) m_adv = d;
  endfunction

  always @(negedge clk) begin
    cyc++;
    // response channel
    rsp_valid = 1'b0;
    if (pend) begin
      if (pcnt == 0) begin
        rsp_valid = 1'b1;
        rsp_rdata = pdata;
        pend = 0;
      end else pcnt--;
    end
    // R2: a stalled request must still be there, unchanged
    if (held)
      chk(req_valid && ({req_write, req_phy, req_reg, req_wdata} == held_f),
          "R2 request held", {req_valid, req_write, req_phy, req_reg, req_wdata},
          {1'b1, held_f});
    req_ready = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) != 0);
    if (req_valid && req_ready) begin
      vectors++;
      if (q_wr.size() > 0) begin
        bit wr; int ph; int rg; int dt; string tg;
        wr = q_wr.pop_front(); ph = q_phy.pop_front(); rg = q_reg.pop_front();
        dt = q_dat.pop_front(); tg = q_tag.pop_front();
        if (req_write != wr || int'(req_phy) != ph || int'(req_reg) != rg ||
            (wr && int'(req_wdata) != dt)) begin
          miscompares++;
          $display("FAIL %s: actual wr=%0d phy=%0d reg=%0d data=0x%0h expected wr=%0d phy=%0d reg=%0d data=0x%0h",
                   tg, req_write, req_phy, req_reg, req_wdata, wr, ph, rg, dt);
        end
      end else if (tail_reg >= 0) begin
        if (req_write || int'(req_reg) != tail_reg || int'(req_phy) != tail_phy) begin
          miscompares++;
          $display("FAIL R6/R10 poll tail: actual wr=%0d reg=%0d expected wr=0 reg=%0d",
                   req_write, req_reg, tail_reg);
        end
      end else begin
        miscompares++;
        $display("FAIL R2 unexpected command: actual reg=%0d expected none", req_reg);
      end
      if (req_write) begin
        model_write(req_phy, req_reg, req_wdata);
        pdata = 16'h0000;
      end else pdata = model_read(req_phy, req_reg);
      pend = 1;
      pcnt = lat - 1;
    end
    held = req_valid && !req_ready;
    held_f = {req_write, req_phy, req_reg, req_wdata};
    // R12: never done while expected commands remain
    if (running && q_wr.size() > 0)
      chk(!cfg_done, "R12 done early", cfg_done, 0);
    if (cyc > 150000 && !finished) begin
      miscompares++;
      $display("FAIL watchdog: actual cycle %0d expected end before 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic run_case(input string name, input bit probe, input bit an,
                          input bit f10, input bit fhalf, input int cfg_addr,
                          input int resp, input int rst_reads, input int an_reads,
                          input int part, input int gig, input bit gstuck,
                          input int l, input int sm, input bit poke);
    int  p, spd, ful, fv, rb, fin;
    bit  exp_err;
    bit  found;
    exp_err = 0; spd = 0; ful = 0; p = cfg_addr; found = 0;
    m_resp = resp; m_ctrl = 16'h1140; m_adv = 16'h0000;
    m_part = part[15:0]; m_gig = gig[15:0]; m_gig_stuck = gstuck;
    m_rst_left = 0; m_an_left = -1; m_an_done = 0;
    cfg_rst_reads = rst_reads; cfg_an_reads = an_reads;
    lat = l; stall_mod = sm; tail_reg = -1;
    if (probe) begin
      for (int a = 0; a < 32; a++) begin
        push(0, a, 0, 0, "R3 probe read");
        if (a == resp) begin
          push(1, a, 0, 16'h0140, "R3 probe flip");
          push(0, a, 0, 0, "R3 probe reread");
          push(1, a, 0, 16'h1140, "R3 probe restore");
          p = a; found = 1;
          break;
        end
        push(1, a, 0, 16'hEFFF, "R4 probe flip");
        push(0, a, 0, 0, "R4 probe reread");
      end
      if (!found) exp_err = 1;
    end
    if (!exp_err) begin
      push(1, p, 0, 16'h8000, "R5 reset write");
      tail_phy = p;
      if (rst_reads < 0) begin
        tail_reg = 0; exp_err = 1;
      end else begin
        for (int i = 0; i <= rst_reads; i++) push(0, p, 0, 0, "R5 reset poll");
      end
    end
    if (!exp_err && an) begin
      push(1, p, 4, 16'h01E1, "R7 advertise");
      push(1, p, 0, 16'h1200, "R7 restart");
      if (an_reads < 0) begin
        tail_reg = 1; exp_err = 1;
      end else begin
        for (int i = 0; i <= an_reads; i++) push(0, p, 1, 0, "R7 status poll");
        push(0, p, 5, 0, "R8 partner read");
        push(0, p, 10, 0, "R8 gigabit read");
        if (gig[11])       begin spd = 2; ful = 1; end
        else if (gig[10])  begin spd = 2; ful = 0; end
        else if (part[8])  begin spd = 1; ful = 1; end
        else if (part[7])  begin spd = 1; ful = 0; end
        else if (part[6])  begin spd = 0; ful = 1; end
        else               begin spd = 0; ful = 0; end
        fin = 16'h1200 | (spd == 2 ? 16'h0040 : 0) | (spd == 1 ? 16'h2000 : 0) |
              (ful ? 16'h0100 : 0);
        push(1, p, 0, fin, "R9 final write");
      end
    end else if (!exp_err) begin
      fv = 16'h2100;
      if (f10)   fv = fv & ~16'h2000;
      if (fhalf) fv = fv & ~16'h0100;
      push(1, p, 0, fv, "R11 forced write");
      push(0, p, 0, 0, "R11 forced read");
      rb = fv | (gstuck ? 16'h0040 : 0);
      ful = rb[8];
      spd = rb[6] ? 2 : (rb[13] ? 1 : 0);
    end
    // launch
    probe_en = probe; autoneg_en = an; force_10 = f10; force_half = fhalf;
    phy_addr_cfg = cfg_addr[4:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    probe_en = ~probe; autoneg_en = ~an; force_10 = ~f10;
    chk(!cfg_done && !cfg_error, {"R12 flags cleared by start ", name},
        {cfg_done, cfg_error}, 0);
    running = 1;
    for (int w = 0; w < 20000; w++) begin
      if (cfg_done) break;
      if (poke && w == 10) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    running = 0;
    chk(cfg_done, {"R12 done ", name}, cfg_done, 1);
    chk(cfg_error == exp_err, {exp_err ? "R4/R6/R10 error " : "R12 no error ", name},
        cfg_error, exp_err);
    chk(q_wr.size() == 0, {"R2 all commands issued ", name}, q_wr.size(), 0);
    if (!exp_err) begin
      chk(int'(link_speed) == spd, {"R8/R11 speed ", name}, link_speed, spd);
      chk(int'(link_full) == ful, {"R8/R11 duplex ", name}, link_full, ful);
      chk(int'(phy_addr_sel) == p, {"R3 address ", name}, phy_addr_sel, p);
    end
    // R12: flags stay while idle
    repeat (4) @(negedge clk);
    chk(cfg_done && (cfg_error == exp_err), {"R12 sticky ", name},
        {cfg_done, cfg_error}, {1'b1, exp_err});
    while (pend) @(negedge clk);
    q_wr.delete(); q_phy.delete(); q_reg.delete(); q_dat.delete(); q_tag.delete();
    tail_reg = -1;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    probe_en = 0; autoneg_en = 0; force_10 = 0; force_half = 0; phy_addr_cfg = '0;
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_rdata = '0;
    repeat (3) @(negedge clk);
    chk(!cfg_done && !cfg_error && !req_valid, "R12 reset state",
        {cfg_done, cfg_error, req_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!cfg_done && !req_valid, "R1 idle without start", {cfg_done, req_valid}, 0);

    //        name        prb an f10 fh addr resp rst an  part     gig     stk lat sm poke
    run_case("an_1g_full", 0, 1, 0, 0, 3,  3,  2,  3, 16'h0000, 16'h0800, 0, 1, 0, 0);
    run_case("an_1g_half", 0, 1, 0, 0, 3,  3,  0,  0, 16'h0100, 16'h0400, 0, 2, 3, 0);
    run_case("an_100f",    0, 1, 0, 0, 7,  7,  1,  2, 16'h01C0, 16'h0000, 0, 3, 0, 0);
    run_case("an_100h",    0, 1, 0, 0, 7,  7,  1,  1, 16'h00C0, 16'h0000, 0, 1, 4, 0);
    run_case("an_10f",     0, 1, 0, 0, 0,  0,  0,  0, 16'h0040, 16'h0000, 0, 1, 0, 0);
    run_case("an_10h",     0, 1, 0, 0, 0,  0,  0,  0, 16'h0000, 16'h0000, 0, 2, 0, 1);
    run_case("probe_5",    1, 1, 0, 0, 0,  5,  2,  2, 16'h0100, 16'h0000, 0, 1, 3, 0);
    run_case("probe_31",   1, 0, 0, 0, 0, 31,  1,  0, 16'h0000, 16'h0000, 0, 1, 0, 0);
    run_case("probe_none", 1, 1, 0, 0, 0, -1,  0,  0, 16'h0000, 16'h0000, 0, 1, 0, 0);
    run_case("rst_stuck",  0, 1, 0, 0, 2,  2, -1,  0, 16'h0000, 16'h0000, 0, 2, 0, 0);
    run_case("an_stuck",   0, 1, 0, 0, 2,  2,  0, -1, 16'h0000, 16'h0000, 0, 1, 0, 0);
    run_case("forced_def", 0, 0, 0, 0, 9,  9,  1,  0, 16'h0000, 16'h0000, 0, 1, 0, 1);
    run_case("forced_10h", 0, 0, 1, 1, 9,  9,  0,  0, 16'h0000, 16'h0000, 0, 2, 3, 0);
    run_case("forced_1gh", 0, 0, 0, 1, 4,  4,  0,  0, 16'h0000, 16'h0000, 1, 1, 0, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule